// File: doc/BRIEF.md
# Instruction Miss Queue with Thread Wakeup

This block sits beside the instruction cache of a single-pipeline multithreaded core and collects the cache misses of up to four hardware threads. Each miss names a block address and a thread. A miss to a block that is already waiting in the queue does not take a new slot: the thread is added to that slot's bitmask of waiters, so every block is read from memory at most once however many threads want it. A miss clears the thread's ready bit, and the thread is taken out of scheduling.

Queued blocks go to one memory read port, one read at a time, and the oldest queued block that may be dispatched goes first. While a cache segment is locked, a block whose address falls inside the locked range is held back. Reads from the loop prefetcher share the same port and get it only when no demand block is eligible. When a read returns, the block is reported as present and every waiting thread of the matching slot has its ready bit set in the same cycle. The slot is then freed. A busy flag tells the prefetcher whether a read is outstanding. When every slot is taken, a miss to a new block raises a stall and is not recorded.

The port is controlled by a three-state machine. `PORT_IDLE` has no read outstanding. It takes the transition *issue demand* to `PORT_WAIT_DEMAND` when an eligible slot exists. Otherwise it takes *grant prefetch* to `PORT_WAIT_PREFETCH` when the prefetcher asks. Both wait states take *read returned* back to `PORT_IDLE` on a memory response.

Top module: `imiss_queue`

## Requirements
- R1: After reset every thread_ready bit is 1, mem_busy is 0, mem_req_valid is 0 and miss_stall is 0.
- R2: A miss (miss_valid with miss_tid given as a binary thread number, where thread_ready bit i belongs to thread i) to a block not yet queued takes a free slot and clears that thread's thread_ready bit at the next clock edge.
- R3: A miss to a block address already held in a slot adds the thread to that slot and allocates nothing new. That block is read from memory once, and one response wakes every thread in the slot.
- R4: At most one memory read is outstanding. mem_busy rises on the edge that ends a cycle with mem_req_valid high, and it falls on the edge that sees mem_rsp_valid. mem_req_valid stays low while mem_busy is high.
- R5: Among the queued blocks that may be dispatched and are not yet sent, the oldest one is sent first.
- R6: While lock_en is 1, a queued block whose address A satisfies lock_lo <= A <= lock_hi (both bounds included) is not sent. It becomes eligible again when lock_en is 0.
- R7: In PORT_IDLE an eligible queued block takes the port before a prefetch request. A prefetch request gets the port (pf_grant and mem_req_pf high, mem_req_addr = pf_addr) only when no queued block is eligible.
- R8: On mem_rsp_valid, every thread held in the slot whose address equals mem_rsp_addr gets thread_ready set at the next edge, and the slot is freed. In that same next cycle present_valid is 1 with present_addr = mem_rsp_addr, for one cycle.
- R9: When all slots are taken, a miss to a block that is not queued raises miss_stall in that same cycle. The miss is not recorded and the thread's ready bit is left unchanged.
- R10: A miss whose address equals mem_rsp_addr in a cycle with mem_rsp_valid is not queued, and that thread's ready bit stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Cache miss this cycle |
| miss_tid | input | 2 | Missing thread number |
| miss_addr | input | 8 | Missing block address |
| lock_en | input | 1 | Locked segment active |
| lock_lo | input | 8 | Lowest locked block address |
| lock_hi | input | 8 | Highest locked block address |
| pf_valid | input | 1 | Prefetcher wants a read |
| pf_addr | input | 8 | Prefetch block address |
| pf_grant | output | 1 | Prefetch read accepted this cycle |
| mem_req_valid | output | 1 | Read request to memory |
| mem_req_addr | output | 8 | Requested block address |
| mem_req_pf | output | 1 | Request comes from the prefetcher |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_addr | input | 8 | Returned block address |
| mem_busy | output | 1 | A read is outstanding |
| miss_stall | output | 1 | Queue full, miss not taken |
| thread_ready | output | 4 | Per-thread ready bits |
| present_valid | output | 1 | Block became present |
| present_addr | output | 8 | Address of the present block |

## Verification
The assertions assume that memory returns data only while a read is outstanding, and only for the address that was requested. They also assume that lock_lo never exceeds lock_hi while lock_enis set. The vector table is written to meet these conditions: every response comes one or more cycles after the matching request and carries the requested address, and the locked range is a fixed ordered pair of addresses. A stalled miss is shown for one cycle only and then dropped, so the bench never offers a miss that breaks the single-slot-per-address rule.

// File: rtl/imq_pkg.sv
package imq_pkg;
    typedef enum logic [1:0] {
        PORT_IDLE          = 2'd0,
        PORT_WAIT_DEMAND   = 2'd1,
        PORT_WAIT_PREFETCH = 2'd2
    } port_state_e;
endpackage

// File: rtl/imq_slot_store.sv
module imq_slot_store #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int NT     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic [NT-1:0]     miss_mask,
    input  logic              rsp_valid,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic              issue_en,
    input  logic              lock_en,
    input  logic [ADDR_W-1:0] lock_lo,
    input  logic [ADDR_W-1:0] lock_hi,
    output logic              cand_valid,
    output logic [ADDR_W-1:0] cand_addr,
    output logic              accept,
    output logic              stall,
    output logic [NT-1:0]     wake_mask
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              q_v   [DEPTH];
    logic              q_iss [DEPTH];
    logic [ADDR_W-1:0] q_addr[DEPTH];
    logic [NT-1:0]     q_tm  [DEPTH];
    logic [CNT_W-1:0]  q_count;

    logic              m_v   [DEPTH+1];
    logic              m_iss [DEPTH+1];
    logic [ADDR_W-1:0] m_addr[DEPTH+1];
    logic [NT-1:0]     m_tm  [DEPTH+1];

    logic              n_v   [DEPTH];
    logic              n_iss [DEPTH];
    logic [ADDR_W-1:0] n_addr[DEPTH];
    logic [NT-1:0]     n_tm  [DEPTH];
    logic [CNT_W-1:0]  n_count;

    logic [DEPTH-1:0] hit_vec, rsp_vec, elig;
    logic             any_hit, rsp_any, full, rsp_same, alloc, merge;
    logic [IDX_W-1:0] cand_idx, rm_idx;
    logic [CNT_W-1:0] cnt_after;

    function automatic logic in_lock(input logic [ADDR_W-1:0] a);
        return lock_en && (a >= lock_lo) && (a <= lock_hi);
    endfunction

    // slot matching and dispatch eligibility
    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_match
            assign hit_vec[g] = q_v[g] && (q_addr[g] == miss_addr);
            assign rsp_vec[g] = rsp_valid && q_v[g] && (q_addr[g] == rsp_addr);
            assign elig[g]    = q_v[g] && !q_iss[g] && !in_lock(q_addr[g]);
        end
    endgenerate

    assign any_hit  = |hit_vec;
    assign rsp_any  = |rsp_vec;
    assign full     = (q_count == CNT_W'(DEPTH));
    assign rsp_same = rsp_valid && (rsp_addr == miss_addr);
    assign accept   = miss_valid && !rsp_same && (any_hit || !full);
    assign stall    = miss_valid && !rsp_same && !any_hit && full;
    assign alloc    = accept && !any_hit;
    assign merge    = accept && any_hit;

    // oldest eligible slot (lowest index) and the slot being filled
    always_comb begin
        cand_valid = 1'b0;
        cand_idx   = '0;
        rm_idx     = '0;
        wake_mask  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (elig[i]) begin
                cand_valid = 1'b1;
                cand_idx   = IDX_W'(i);
            end
            if (rsp_vec[i]) begin
                rm_idx    = IDX_W'(i);
                wake_mask = wake_mask | q_tm[i];
            end
        end
    end
    assign cand_addr = q_addr[cand_idx];
    assign cnt_after = q_count - CNT_W'(rsp_any);

    // next slot contents: merge, mark issued, compact on fill, append
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            m_v[i]    = q_v[i];
            m_addr[i] = q_addr[i];
            m_iss[i]  = q_iss[i] | (issue_en && cand_valid && (cand_idx == IDX_W'(i)));
            m_tm[i]   = q_tm[i] | ((merge && hit_vec[i]) ? miss_mask : '0);
        end
        m_v[DEPTH]    = 1'b0;
        m_iss[DEPTH]  = 1'b0;
        m_addr[DEPTH] = '0;
        m_tm[DEPTH]   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rsp_any && (i >= int'(rm_idx))) begin
                n_v[i]    = m_v[i+1];
                n_iss[i]  = m_iss[i+1];
                n_addr[i] = m_addr[i+1];
                n_tm[i]   = m_tm[i+1];
            end else begin
                n_v[i]    = m_v[i];
                n_iss[i]  = m_iss[i];
                n_addr[i] = m_addr[i];
                n_tm[i]   = m_tm[i];
            end
            if (alloc && (i == int'(cnt_after))) begin
                n_v[i]    = 1'b1;
                n_iss[i]  = 1'b0;
                n_addr[i] = miss_addr;
                n_tm[i]   = miss_mask;
            end
        end
        n_count = cnt_after + CNT_W'(alloc);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_count <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                q_v[i]    <= 1'b0;
                q_iss[i]  <= 1'b0;
                q_addr[i] <= '0;
                q_tm[i]   <= '0;
            end
        end else begin
            q_count <= n_count;
            for (int i = 0; i < DEPTH; i++) begin
                q_v[i]    <= n_v[i];
                q_iss[i]  <= n_iss[i];
                q_addr[i] <= n_addr[i];
                q_tm[i]   <= n_tm[i];
            end
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> (q_count < CNT_W'(DEPTH)));
    assert_unique_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    assert_fill_unique_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_vec));
    assert_issue_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_en |-> cand_valid);
endmodule

// File: rtl/imq_port_fsm.sv
module imq_port_fsm
    import imq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cand_valid,
    input  logic pf_valid,
    input  logic rsp_valid,
    output logic issue_en,
    output logic pf_grant,
    output logic busy
);
    port_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PORT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d  = state_q;
        issue_en = 1'b0;
        pf_grant = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            PORT_IDLE: begin
                if (cand_valid) begin
                    issue_en = 1'b1;
                    state_d  = PORT_WAIT_DEMAND;
                end else if (pf_valid) begin
                    pf_grant = 1'b1;
                    state_d  = PORT_WAIT_PREFETCH;
                end
            end
            PORT_WAIT_DEMAND: begin
                busy = 1'b1;
                if (rsp_valid) state_d = PORT_IDLE;
            end
            PORT_WAIT_PREFETCH: begin
                busy = 1'b1;
                if (rsp_valid) state_d = PORT_IDLE;
            end
            default: state_d = PORT_IDLE;
        endcase
    end

    assert_rsp_when_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (state_q != PORT_IDLE));
    assert_demand_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_grant |-> !cand_valid);
endmodule

// File: rtl/imq_ready_bits.sv
module imq_ready_bits #(
    parameter int NT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NT-1:0] clr_mask,
    input  logic [NT-1:0] set_mask,
    output logic [NT-1:0] ready
);
    always_ff @(posedge clk) begin
        if (!rst_n) ready <= '1;
        else        ready <= (ready & ~clr_mask) | set_mask;
    end

    genvar t;
    generate
        for (t = 0; t < NT; t++) begin : g_chk
            assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
                set_mask[t] |=> ready[t]);
            assert_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_mask[t] && !set_mask[t]) |=> !ready[t]);
        end
    endgenerate
endmodule

// File: rtl/imiss_queue.sv
module imiss_queue #(
    parameter int DEPTH  = 4,
    parameter int ADDR_W = 8,
    parameter int NT     = 4,
    localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [TID_W-1:0]  miss_tid,
    input  logic [ADDR_W-1:0] miss_addr,
    input  logic              lock_en,
    input  logic [ADDR_W-1:0] lock_lo,
    input  logic [ADDR_W-1:0] lock_hi,
    input  logic              pf_valid,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              pf_grant,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_pf,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_addr,
    output logic              mem_busy,
    output logic              miss_stall,
    output logic [NT-1:0]     thread_ready,
    output logic              present_valid,
    output logic [ADDR_W-1:0] present_addr
);
    logic              cand_valid, accept, issue_en;
    logic [ADDR_W-1:0] cand_addr;
    logic [NT-1:0]     miss_mask, wake_mask, clr_mask;

    assign miss_mask = NT'(1) << miss_tid;
    assign clr_mask  = accept ? miss_mask : '0;

    imq_slot_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .NT(NT)) store_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_addr(miss_addr), .miss_mask(miss_mask),
        .rsp_valid(mem_rsp_valid), .rsp_addr(mem_rsp_addr),
        .issue_en(issue_en),
        .lock_en(lock_en), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .cand_valid(cand_valid), .cand_addr(cand_addr),
        .accept(accept), .stall(miss_stall), .wake_mask(wake_mask)
    );

    imq_port_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .cand_valid(cand_valid), .pf_valid(pf_valid), .rsp_valid(mem_rsp_valid),
        .issue_en(issue_en), .pf_grant(pf_grant), .busy(mem_busy)
    );

    imq_ready_bits #(.NT(NT)) ready_i (
        .clk(clk), .rst_n(rst_n),
        .clr_mask(clr_mask), .set_mask(wake_mask), .ready(thread_ready)
    );

    assign mem_req_valid = issue_en | pf_grant;
    assign mem_req_pf    = pf_grant;
    assign mem_req_addr  = issue_en ? cand_addr : pf_addr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            present_valid <= 1'b0;
            present_addr  <= '0;
        end else begin
            present_valid <= mem_rsp_valid;
            present_addr  <= mem_rsp_addr;
        end
    end

    assert_one_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> (mem_busy && !mem_req_valid));
    assert_lock_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_pf && lock_en) |->
            !((mem_req_addr >= lock_lo) && (mem_req_addr <= lock_hi)));
    assert_present_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |=> (present_valid && present_addr == $past(mem_rsp_addr)));
endmodule

// File: tb/imiss_queue_tb.sv
`timescale 1ns/1ps
module imiss_queue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       miss_valid, lock_en, pf_valid, mem_rsp_valid;
    logic [1:0] miss_tid;
    logic [7:0] miss_addr, lock_lo, lock_hi, pf_addr, mem_rsp_addr;
    logic       pf_grant, mem_req_valid, mem_req_pf, mem_busy, miss_stall, present_valid;
    logic [7:0] mem_req_addr, present_addr;
    logic [3:0] thread_ready;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    imiss_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_tid(miss_tid), .miss_addr(miss_addr),
        .lock_en(lock_en), .lock_lo(lock_lo), .lock_hi(lock_hi),
        .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_grant(pf_grant),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_pf(mem_req_pf),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_addr(mem_rsp_addr),
        .mem_busy(mem_busy), .miss_stall(miss_stall), .thread_ready(thread_ready),
        .present_valid(present_valid), .present_addr(present_addr)
    );

    typedef struct packed {
        logic       mv;
        logic [1:0] tid;
        logic [7:0] ma;
        logic       rv;
        logic [7:0] ra;
        logic       pv;
        logic       lk;
        logic       e_req;
        logic [7:0] e_addr;
        logic       e_pf;
        logic       e_stall;
        logic [3:0] e_ready;
        logic       e_busy;
    } vec_t;

    // lock range fixed at 0x40..0x4F, prefetch address fixed at 0x80
    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd0, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1110, 1'b0}, // R2 new slot
        '{1'b1, 2'd1, 8'h10, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h10, 1'b0, 1'b0, 4'b1100, 1'b1}, // R3 merge, R4 issue
        '{1'b1, 2'd2, 8'h20, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1000, 1'b1}, // R4 no req while busy
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1011, 1'b0}, // R3 R8 one fill wakes t0,t1
        '{1'b1, 2'd3, 8'h4F, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h20, 1'b0, 1'b0, 4'b0011, 1'b1}, // R7 demand beats prefetch
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h20, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0111, 1'b0}, // R8 wake t2
        '{1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 8'h80, 1'b1, 1'b0, 4'b0111, 1'b1}, // R6 0x4F held, R7 prefetch
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h80, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0111, 1'b0}, // R8 prefetch return
        '{1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h4F, 1'b0, 1'b0, 4'b0111, 1'b1}, // R6 unlocked dispatch
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h4F, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1111, 1'b0}, // R8 wake t3
        '{1'b1, 2'd0, 8'h01, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1110, 1'b0}, // R2
        '{1'b1, 2'd1, 8'h02, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h01, 1'b0, 1'b0, 4'b1100, 1'b1}, // R2 R4
        '{1'b1, 2'd2, 8'h03, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b1000, 1'b1}, // R2
        '{1'b1, 2'd3, 8'h04, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0000, 1'b1}, // R2 fills last slot
        '{1'b1, 2'd0, 8'h05, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 4'b0000, 1'b1}, // R9 full, stall
        '{1'b0, 2'd0, 8'h00, 1'b1, 8'h01, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0001, 1'b0}, // R8 wake t0
        '{1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h02, 1'b0, 1'b0, 4'b0001, 1'b1}, // R5 oldest first
        '{1'b1, 2'd0, 8'h02, 1'b1, 8'h02, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 4'b0011, 1'b0}, // R10 miss meets fill
        '{1'b0, 2'd0, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h03, 1'b0, 1'b0, 4'b0011, 1'b1}  // R5 next oldest
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        miss_valid = 0; miss_tid = 0; miss_addr = 0;
        pf_valid = 0; mem_rsp_valid = 0; mem_rsp_addr = 0; lock_en = 0;
    endtask

    initial begin
        lock_lo = 8'h40; lock_hi = 8'h4F; pf_addr = 8'h80;
        idle_inputs();
        rst_n = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready after reset", 32'(thread_ready), 32'hF);
        chk("R1 busy after reset", 32'(mem_busy), 0);
        chk("R1 no request after reset", 32'(mem_req_valid), 0);
        chk("R1 no stall after reset", 32'(miss_stall), 0);
        rst_n = 1;

        for (int i = 0; i < NV; i++) begin
            miss_valid = VECS[i].mv; miss_tid = VECS[i].tid; miss_addr = VECS[i].ma;
            mem_rsp_valid = VECS[i].rv; mem_rsp_addr = VECS[i].ra;
            pf_valid = VECS[i].pv; lock_en = VECS[i].lk;
            #1;
            chk($sformatf("vec%0d request", i),
                {mem_req_valid, (mem_req_valid ? mem_req_addr : 8'h00), mem_req_pf & mem_req_valid},
                {VECS[i].e_req, VECS[i].e_addr, VECS[i].e_pf});
            chk($sformatf("vec%0d stall", i), 32'(miss_stall), 32'(VECS[i].e_stall));
            @(negedge clk);
            chk($sformatf("vec%0d ready", i), 32'(thread_ready), 32'(VECS[i].e_ready));
            chk($sformatf("vec%0d busy", i), 32'(mem_busy), 32'(VECS[i].e_busy));
        end

        // R8: fill of 0x03 wakes t2, present pulse lasts one cycle
        idle_inputs();
        mem_rsp_valid = 1; mem_rsp_addr = 8'h03;
        @(negedge clk);
        mem_rsp_valid = 0;
        chk("R8 present after fill", {31'(present_valid), present_addr}, {31'd1, 8'h03});
        chk("R8 wake t2", 32'(thread_ready), 32'b0111);
        #1;
        chk("R5 slot 0x04 sent", {mem_req_valid, mem_req_addr}, {1'b1, 8'h04});
        @(negedge clk);
        chk("R8 present one cycle", 32'(present_valid), 0);
        chk("R4 busy while 0x04 out", 32'(mem_busy), 1);

        // R1: reset in the middle of activity
        rst_n = 0;
        @(negedge clk);
        chk("R1 ready on mid reset", 32'(thread_ready), 32'hF);
        chk("R1 idle on mid reset", {mem_busy, mem_req_valid}, 0);
        rst_n = 1;

        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule